// File: doc/BRIEF.md
# Limit Watchdog Interrupt Controller

This block checks each new measurement from a hardware monitor against the limits programmed for its channel. It records every out-of-limit event, and every external event, in sticky status bits. From those bits it raises two hardware interrupt lines: a system-management line `smi_o` and a general interrupt line `irq_o`. A measurement sequencer presents a channel index and a value with a one-cycle strobe. The block then reads the high and low limits of that channel from an external limit store, which has a one-cycle synchronous read. Software reads and clears the status, and programs the masks and enables, through a small register port with one-cycle read latency.

A three-state sequencer runs each check:
- `ST_IDLE` moves to `ST_FETCH` when a strobe arrives. The channel and the value are captured and the channel is put on `lim_addr`.
- `ST_FETCH` always moves to `ST_CHECK`. This cycle waits for the limit store.
- `ST_CHECK` always moves back to `ST_IDLE`. The comparison is made here and any violation is recorded.

Channels 0 to 6 are voltages, channel 7 is the temperature and channels 8 to 10 are fan tachometer counts. Status bit n belongs to channel n. Bits 11, 12 and 13 belong to the board-temperature chain input, the chassis-intrusion input and the POST-buffer overflow pulse.

Top module: `limwd_irq_ctrl`

## Requirements
- R1: After reset, every status, source-mask, configuration and output-block register reads as 0, and `smi_o` and `irq_o` are low.
- R2: A voltage channel (0 to 6) is out of limit when its value is above `lim_hi` or below `lim_lo`, compared as unsigned numbers. A value equal to either limit is not a violation. A violation sets status bit n, where n is the channel.
- R3: The temperature channel (7) is out of limit only when its value, read as a two's-complement number, is greater than `lim_hi`, also read as two's complement. A violation sets status bit 7.
- R4: A fan channel (8 to 10) is out of limit only when its count is above `lim_hi`. `lim_lo` is ignored for fans. A violation sets status bit n, so fan channels use bits 0 to 2 of status register 1.
- R5: Status bits are sticky. A read of address 0 returns status bits 7:0 and a read of address 1 returns bits 15:8. The data appears on `reg_rdata` with `reg_rvalid` high one cycle after `reg_rd`. The read clears the bits it returned, except any bit that is set again in the same cycle, which stays set.
- R6: `ext_board_temp` sets bit 11 (status 1, bit 3), `ext_intrusion` sets bit 12 (status 1, bit 4) and `post_overflow` sets bit 13 (status 1, bit 5). Each input is active high and is sampled every cycle.
- R7: The source masks sit at address 2 (bits 7:0) and address 3 (bits 15:8), one mask bit per status bit, and a 1 masks that source. A masked source is still recorded in status but does not reach either output.
- R8: Configuration register (address 4): bit 0 enables `smi_o` and bit 1 enables `irq_o`. Output-block register (address 5): bit 0 blocks `smi_o` and bit 1 blocks `irq_o`. Each output is high when it is enabled, not blocked, and at least one unmasked status bit is set. The outputs are registered and follow the registers one cycle later.
- R9: A strobe is accepted only in `ST_IDLE`. Strobes in `ST_FETCH` or `ST_CHECK` are ignored. `lim_addr` shows the accepted channel from the cycle after acceptance, and the status bit is set on the second clock edge after acceptance.
- R10: A channel index above 10 sets no status bit.
- R11: Writes to the status addresses 0 and 1 have no effect. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | Measurement strobe |
| meas_chan | input | CH_W | Channel index of the measurement |
| meas_value | input | DW | Measured value |
| lim_addr | output | CH_W | Channel index sent to the limit store |
| lim_hi | input | DW | High limit, valid one cycle after `lim_addr` |
| lim_lo | input | DW | Low limit, valid one cycle after `lim_addr` |
| ext_board_temp | input | 1 | Chained board-temperature event |
| ext_intrusion | input | 1 | Chassis intrusion event |
| post_overflow | input | 1 | POST code buffer overflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reg_rvalid | output | 1 | Read data valid |
| smi_o | output | 1 | System-management interrupt |
| irq_o | output | 1 | General interrupt |

## Verification
A wrong internal state here shows up at the ports within a few cycles. A sequencer that stalls outside `ST_IDLE` makes later measurements vanish, and a status read two edges later returns 0 where a bit was expected. A status bit that is set wrongly or fails to clear shows in the next status read. While the outputs are enabled, it also moves `smi_o` or `irq_o` one cycle after the bad bit appears. A wrong mask or enable register is seen on the outputs one cycle after the write, and on its own read-back one cycle after the read strobe.

// File: rtl/limwd_pkg.sv
package limwd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CHECK = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        CLS_VOLT = 2'd0,
        CLS_TEMP = 2'd1,
        CLS_FAN  = 2'd2,
        CLS_NONE = 2'd3
    } chan_class_t;

    localparam int RAW = 3;
    localparam int RDW = 8;

    localparam logic [RAW-1:0] A_STAT0 = 3'd0;
    localparam logic [RAW-1:0] A_MASK0 = 3'd2;
    localparam logic [RAW-1:0] A_CFG   = 3'd4;
    localparam logic [RAW-1:0] A_OBLK  = 3'd5;

endpackage

// File: rtl/limwd_cmp.sv
module limwd_cmp
    import limwd_pkg::*;
#(
    parameter int NUM_VOLT = 7,
    parameter int NUM_FAN  = 3,
    parameter int CH_W     = 4,
    parameter int DW       = 8
) (
    input  logic [CH_W-1:0] chan,
    input  logic [DW-1:0]   value,
    input  logic [DW-1:0]   hi,
    input  logic [DW-1:0]   lo,
    output chan_class_t     cls,
    output logic            viol
);
    localparam logic [CH_W-1:0] TEMP_IDX = CH_W'(NUM_VOLT);
    localparam logic [CH_W-1:0] LAST_FAN = CH_W'(NUM_VOLT + NUM_FAN);

    always_comb begin
        if (chan < TEMP_IDX)       cls = CLS_VOLT;
        else if (chan == TEMP_IDX) cls = CLS_TEMP;
        else if (chan <= LAST_FAN) cls = CLS_FAN;
        else                       cls = CLS_NONE;
    end

    always_comb begin
        unique case (cls)
            CLS_VOLT: viol = (value > hi) || (value < lo);
            CLS_TEMP: viol = $signed(value) > $signed(hi);
            CLS_FAN:  viol = value > hi;
            default:  viol = 1'b0;
        endcase
    end

    // R10
    always_comb begin
        no_class_chk: assert ((cls != CLS_NONE) || !viol);
    end

endmodule

// File: rtl/limwd_regs.sv
module limwd_regs
    import limwd_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [RDW-1:0]  reg_wdata,
    input  logic [SW-1:0]   set_vec,
    output logic [RDW-1:0]  reg_rdata,
    output logic            reg_rvalid,
    output logic [SW-1:0]   status,
    output logic [SW-1:0]   src_mask,
    output logic            en_smi,
    output logic            en_irq,
    output logic            blk_smi,
    output logic            blk_irq
);
    localparam int NB = SW / RDW;

    logic [SW-1:0]  status_q;
    logic [SW-1:0]  mask_q;
    logic [SW-1:0]  clr_vec;
    logic [1:0]     cfg_q;
    logic [1:0]     blk_q;
    logic [RDW-1:0] rd_mux;

    for (genvar g = 0; g < NB; g++) begin : g_clr
        assign clr_vec[g*RDW +: RDW] =
            {RDW{reg_rd && (reg_addr == A_STAT0 + RAW'(g))}};
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NB; b++) begin
            if (reg_addr == A_STAT0 + RAW'(b)) rd_mux = status_q[b*RDW +: RDW];
            if (reg_addr == A_MASK0 + RAW'(b)) rd_mux = mask_q[b*RDW +: RDW];
        end
        if (reg_addr == A_CFG)  rd_mux = {6'd0, cfg_q};
        if (reg_addr == A_OBLK) rd_mux = {6'd0, blk_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q   <= '0;
            mask_q     <= '0;
            cfg_q      <= '0;
            blk_q      <= '0;
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
            status_q <= (status_q & ~clr_vec) | set_vec;
            if (reg_wr) begin
                for (int b = 0; b < NB; b++) begin
                    if (reg_addr == A_MASK0 + RAW'(b))
                        mask_q[b*RDW +: RDW] <= reg_wdata;
                end
                if (reg_addr == A_CFG)  cfg_q <= reg_wdata[1:0];
                if (reg_addr == A_OBLK) blk_q <= reg_wdata[1:0];
            end
        end
    end

    assign status   = status_q;
    assign src_mask = mask_q;
    assign en_smi   = cfg_q[0];
    assign en_irq   = cfg_q[1];
    assign blk_smi  = blk_q[0];
    assign blk_irq  = blk_q[1];

    for (genvar g = 0; g < NB; g++) begin : g_chk
        // R5
        stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_vec[g*RDW] |=> ((status_q[g*RDW +: RDW] & $past(status_q[g*RDW +: RDW]))
                                 == $past(status_q[g*RDW +: RDW])));
        // R5
        rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[g*RDW] && (set_vec[g*RDW +: RDW] == '0))
                |=> (status_q[g*RDW +: RDW] == '0));
    end

    // R5
    rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    // R5
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

endmodule

// File: rtl/limwd_irq_out.sv
module limwd_irq_out #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] status,
    input  logic [SW-1:0] src_mask,
    input  logic          en_smi,
    input  logic          en_irq,
    input  logic          blk_smi,
    input  logic          blk_irq,
    output logic          smi_o,
    output logic          irq_o
);
    logic pending;

    assign pending = |(status & ~src_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_o <= 1'b0;
            irq_o <= 1'b0;
        end else begin
            smi_o <= pending && en_smi && !blk_smi;
            irq_o <= pending && en_irq && !blk_irq;
        end
    end

    // R8
    smi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_smi || blk_smi) |=> !smi_o);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_irq || blk_irq) |=> !irq_o);

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~src_mask) == '0) |=> (!smi_o && !irq_o));

endmodule

// File: rtl/limwd_irq_ctrl.sv
module limwd_irq_ctrl
    import limwd_pkg::*;
#(
    parameter int NUM_VOLT = 7,
    parameter int NUM_FAN  = 3,
    parameter int CH_W     = 4,
    parameter int DW       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            meas_valid,
    input  logic [CH_W-1:0] meas_chan,
    input  logic [DW-1:0]   meas_value,
    output logic [CH_W-1:0] lim_addr,
    input  logic [DW-1:0]   lim_hi,
    input  logic [DW-1:0]   lim_lo,
    input  logic            ext_board_temp,
    input  logic            ext_intrusion,
    input  logic            post_overflow,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [2:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic            reg_rvalid,
    output logic            smi_o,
    output logic            irq_o
);
    localparam int NUM_CH   = NUM_VOLT + 1 + NUM_FAN;
    localparam int SW       = 16;
    localparam int BIT_BT   = NUM_CH;
    localparam int BIT_INTR = NUM_CH + 1;
    localparam int BIT_POST = NUM_CH + 2;

    seq_state_t      state_q, state_d;
    logic [CH_W-1:0] chan_q;
    logic [DW-1:0]   val_q;
    chan_class_t     cls;
    logic            viol;
    logic [SW-1:0]   set_vec;
    logic [SW-1:0]   status;
    logic [SW-1:0]   src_mask;
    logic            en_smi, en_irq, blk_smi, blk_irq;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (meas_valid) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_CHECK;
            ST_CHECK: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // capture of the accepted measurement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            val_q  <= '0;
        end else if (state_q == ST_IDLE && meas_valid) begin
            chan_q <= meas_chan;
            val_q  <= meas_value;
        end
    end

    assign lim_addr = chan_q;

    limwd_cmp #(
        .NUM_VOLT (NUM_VOLT),
        .NUM_FAN  (NUM_FAN),
        .CH_W     (CH_W),
        .DW       (DW)
    ) u_cmp (
        .chan  (chan_q),
        .value (val_q),
        .hi    (lim_hi),
        .lo    (lim_lo),
        .cls   (cls),
        .viol  (viol)
    );

    for (genvar i = 0; i < SW; i++) begin : g_set
        if (i < NUM_CH) begin : g_meas
            assign set_vec[i] = (state_q == ST_CHECK) && viol && (chan_q == CH_W'(i));
        end else if (i == BIT_BT) begin : g_bt
            assign set_vec[i] = ext_board_temp;
        end else if (i == BIT_INTR) begin : g_intr
            assign set_vec[i] = ext_intrusion;
        end else if (i == BIT_POST) begin : g_post
            assign set_vec[i] = post_overflow;
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end
    end

    limwd_regs #(.SW(SW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .set_vec    (set_vec),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .status     (status),
        .src_mask   (src_mask),
        .en_smi     (en_smi),
        .en_irq     (en_irq),
        .blk_smi    (blk_smi),
        .blk_irq    (blk_irq)
    );

    limwd_irq_out #(.SW(SW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .status   (status),
        .src_mask (src_mask),
        .en_smi   (en_smi),
        .en_irq   (en_irq),
        .blk_smi  (blk_smi),
        .blk_irq  (blk_irq),
        .smi_o    (smi_o),
        .irq_o    (irq_o)
    );

    // R9
    fetch_to_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_CHECK));

    // R9
    check_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) |=> (state_q == ST_IDLE));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(chan_q));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && meas_valid) |=> (state_q == ST_FETCH && lim_addr == $past(meas_chan)));

endmodule

// File: tb/limwd_irq_ctrl_bench.sv
module limwd_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       meas_valid = 1'b0;
    logic [3:0] meas_chan = '0;
    logic [7:0] meas_value = '0;
    logic [3:0] lim_addr;
    logic [7:0] lim_hi, lim_lo;
    logic       ext_board_temp = 1'b0;
    logic       ext_intrusion = 1'b0;
    logic       post_overflow = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       reg_rvalid;
    logic       smi_o, irq_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] hi_mem [16];
    logic [7:0] lo_mem [16];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    limwd_irq_ctrl u_limwd_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .meas_valid(meas_valid), .meas_chan(meas_chan), .meas_value(meas_value),
        .lim_addr(lim_addr), .lim_hi(lim_hi), .lim_lo(lim_lo),
        .ext_board_temp(ext_board_temp), .ext_intrusion(ext_intrusion),
        .post_overflow(post_overflow),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .smi_o(smi_o), .irq_o(irq_o)
    );

    // limit store with one-cycle synchronous read
    always_ff @(posedge clk) begin
        lim_hi <= hi_mem[lim_addr];
        lim_lo <= lo_mem[lim_addr];
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (reg_rvalid && !done) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R5 unexpected read data actual=%02h expected=none", reg_rdata);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_rd = 1'b1;
        reg_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic measure(input logic [3:0] ch, input logic [7:0] v);
        @(negedge clk);
        meas_valid = 1'b1;
        meas_chan = ch;
        meas_value = v;
        @(negedge clk);
        meas_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_ext(input int which);
        @(negedge clk);
        if (which == 0) ext_board_temp = 1'b1;
        if (which == 1) ext_intrusion = 1'b1;
        if (which == 2) post_overflow = 1'b1;
        @(negedge clk);
        ext_board_temp = 1'b0;
        ext_intrusion = 1'b0;
        post_overflow = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            hi_mem[i] = 8'hC0;
            lo_mem[i] = 8'h40;
        end
        hi_mem[7] = 8'h32;
        for (int i = 8; i < 11; i++) begin
            hi_mem[i] = 8'h99;
            lo_mem[i] = 8'h10;
        end
        for (int i = 11; i < 16; i++) begin
            hi_mem[i] = 8'h00;
            lo_mem[i] = 8'hFF;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 smi_o", {7'd0, smi_o}, 8'h00);
        check("R1 irq_o", {7'd0, irq_o}, 8'h00);
        for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R1 reset register");

        // R2 voltage window, equal is not a violation
        measure(4'd0, 8'hC0);
        measure(4'd1, 8'h40);
        measure(4'd2, 8'hC1);
        measure(4'd3, 8'h3F);
        rd(3'd0, 8'h0C, "R2 voltage window");
        rd(3'd0, 8'h00, "R5 cleared by read");

        // R3 signed temperature
        measure(4'd7, 8'hFB);
        rd(3'd0, 8'h00, "R3 negative temp below limit");
        measure(4'd7, 8'h32);
        rd(3'd0, 8'h00, "R3 temp equal to limit");
        measure(4'd7, 8'h33);
        rd(3'd0, 8'h80, "R3 temp above limit");

        // R4 fan counts, low limit ignored
        measure(4'd8, 8'h05);
        measure(4'd9, 8'h9A);
        measure(4'd10, 8'h99);
        rd(3'd1, 8'h02, "R4 fan above limit");
        rd(3'd0, 8'h00, "R4 fan leaves status0 alone");

        // R10 channels beyond the last fan
        for (int c = 11; c < 16; c++) measure(4'(c), 8'hFF);
        rd(3'd0, 8'h00, "R10 status0 after out-of-range channels");
        rd(3'd1, 8'h00, "R10 status1 after out-of-range channels");

        // R6 external events
        pulse_ext(0);
        pulse_ext(1);
        pulse_ext(2);
        rd(3'd1, 8'h38, "R6 external event bits");
        // R5 set in the same cycle as the read survives
        @(negedge clk);
        ext_intrusion = 1'b1;
        rd(3'd1, 8'h10, "R6 held intrusion");
        rd(3'd1, 8'h10, "R5 set during read survives");
        ext_intrusion = 1'b0;
        rd(3'd1, 8'h10, "R5 last set before release");
        rd(3'd1, 8'h00, "R5 cleared after release");

        // R9 strobes while busy are ignored
        @(negedge clk);
        meas_valid = 1'b1;
        meas_chan = 4'd0;
        meas_value = 8'hFF;
        @(negedge clk);
        check("R9 lim_addr after accept", {4'd0, lim_addr}, 8'h00);
        meas_chan = 4'd1;
        @(negedge clk);
        @(negedge clk);
        meas_valid = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd0, 8'h01, "R9 busy strobes dropped");

        // R7 R8 masks, enables and output blocks
        measure(4'd2, 8'hD0);
        check("R8 smi disabled", {7'd0, smi_o}, 8'h00);
        check("R8 irq disabled", {7'd0, irq_o}, 8'h00);
        wr(3'd4, 8'h03);
        @(negedge clk);
        check("R8 smi enabled", {7'd0, smi_o}, 8'h01);
        check("R8 irq enabled", {7'd0, irq_o}, 8'h01);
        wr(3'd2, 8'h04);
        @(negedge clk);
        check("R7 smi masked source", {7'd0, smi_o}, 8'h00);
        check("R7 irq masked source", {7'd0, irq_o}, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd5, 8'h01);
        @(negedge clk);
        check("R8 smi blocked", {7'd0, smi_o}, 8'h00);
        check("R8 irq open", {7'd0, irq_o}, 8'h01);
        wr(3'd5, 8'h02);
        @(negedge clk);
        check("R8 smi open", {7'd0, smi_o}, 8'h01);
        check("R8 irq blocked", {7'd0, irq_o}, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h01);
        @(negedge clk);
        check("R8 smi only enabled", {7'd0, smi_o}, 8'h01);
        check("R8 irq not enabled", {7'd0, irq_o}, 8'h00);
        rd(3'd4, 8'h01, "R8 config readback");
        rd(3'd5, 8'h00, "R8 block readback");
        wr(3'd3, 8'hA5);
        rd(3'd3, 8'hA5, "R7 mask1 readback");
        wr(3'd3, 8'h00);
        rd(3'd0, 8'h04, "R7 masked source recorded");
        @(negedge clk);
        check("R8 smi drops after clear", {7'd0, smi_o}, 8'h00);

        // R11 status not writable, unused addresses
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        @(negedge clk);
        check("R11 smi after status write", {7'd0, smi_o}, 8'h00);
        rd(3'd0, 8'h00, "R11 status0 write ignored");
        rd(3'd1, 8'h00, "R11 status1 write ignored");
        rd(3'd6, 8'h00, "R11 address 6");
        rd(3'd7, 8'h00, "R11 address 7");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R5 missing read data actual=%0d expected=0 pending", exp_q.size());
        end
        finish_run();
    end

endmodule